// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a range of memory blocks shared by a group of caching nodes. For every block it keeps a coherence state, a bit vector of the nodes holding a copy, the owner's node number when one node holds the block writable, and the block's data. Caches send it miss and write-back requests. It answers with data, sends invalidate and fetch messages to other caches, and keeps its memory current.

The controller handles one request at a time. A request is accepted in `ST_IDLE`. The `ST_DISPATCH` state then reads the directory entry for the block and picks a path:

- Misses on uncached or shared blocks that need no invalidation go directly to `ST_REPLY`.
- A write miss on a shared block that has other sharers goes to `ST_INVAL`. That state sends one invalidate per cycle, lowest node first, and moves to `ST_REPLY` after the last one.
- A miss on an exclusive block goes to `ST_FETCH_SEND`, which sends a single fetch or fetch-and-invalidate message to the owner. `ST_FETCH_WAIT` then holds until the owner's data arrives on `rsp_valid`. That data is written to memory, and the controller moves to `ST_REPLY`.
- A write-back from the owner is applied in `ST_DISPATCH`. Any other write-back is dropped there. Both return to `ST_IDLE`.

`ST_REPLY` sends the data reply, writes the new directory entry and returns to `ST_IDLE`. Outgoing messages carry a kind, a destination node, the block address and data. They have no back-pressure: each is valid for exactly one cycle.

Top module: `coh_dir_home`

## Requirements
- R1: After reset every block is uncached with an empty sharer set and zero data, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read miss (`req_kind` 0) on an uncached block sends a data reply (`msg_kind` 0) carrying the memory data to the requester. The block becomes shared, with the requester as its only sharer.
- R3: A write miss (`req_kind` 1) on an uncached block sends a data reply to the requester. The block becomes exclusive, owned by the requester.
- R4: A read miss on a shared block sends a data reply with the memory data and adds the requester to the sharer set.
- R5: A write miss on a shared block first sends an invalidate (`msg_kind` 1) to each sharer other than the requester. The invalidates go one per cycle in consecutive cycles, in ascending node order. A data reply follows, and the block becomes exclusive, owned by the requester.
- R6: A read miss on an exclusive block sends a fetch (`msg_kind` 2) to the owner and waits for `rsp_valid`. It writes `rsp_data` to memory and replies with that data. The block becomes shared by the old owner and the requester.
- R7: A write miss on an exclusive block sends a fetch-and-invalidate (`msg_kind` 3) to the owner, writes `rsp_data` to memory and replies with it. The requester becomes the new owner and the block stays exclusive.
- R8: A write-back (`req_kind` 2) from the owner of an exclusive block writes `req_wdata` to memory and makes the block uncached with an empty sharer set. It sends no message.
- R9: The following are dropped with no message and no change to the directory or memory: a write-back from a node that is not the owner, a write-back to a block that is not exclusive, and `req_kind` 3.
- R10: `req_ready` is 0 from the cycle after acceptance until the request is finished. Counting the cycle after acceptance as cycle 0:
  - The first message appears in cycle 1, and later messages follow in consecutive cycles.
  - The data reply comes one cycle after the cycle in which a fetch response is accepted.
  - `req_ready` is 1 again in the cycle after the last message, or in cycle 1 for a write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_node | input | NID_W | Requesting node |
| req_addr | input | ADDR_W | Block number |
| req_wdata | input | DATA_W | Write-back data |
| rsp_valid | input | 1 | Owner's data response to a fetch |
| rsp_data | input | DATA_W | Data returned by the owner |
| msg_valid | output | 1 | Outgoing message valid for this cycle |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dest | output | NID_W | Destination node |
| msg_addr | output | ADDR_W | Block number of the message |
| msg_data | output | DATA_W | Data of a data reply |

## Verification
The bench builds the controller with four nodes, four blocks and 32-bit data. With four nodes, a single block can hold three sharers when the fourth node write-misses, so the ascending invalidate order, the gap-free one-per-cycle timing and the exclusion of the requester are all observable on one block. It also lets a block move through every state in sequence. The four blocks give separate blocks on which write-backs to uncached blocks, write-backs from the owner and write misses to uncached blocks are exercised without disturbing one another. A model in the bench tracks state, sharers, owner and data for every block and predicts each message, its destination, its data and its cycle.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dstate_e;

    typedef enum logic [1:0] {
        RQ_RD  = 2'd0,
        RQ_WR  = 2'd1,
        RQ_WB  = 2'd2,
        RQ_NOP = 2'd3
    } rkind_e;

    typedef enum logic [1:0] {
        MG_DATA      = 2'd0,
        MG_INV       = 2'd1,
        MG_FETCH     = 2'd2,
        MG_FETCH_INV = 2'd3
    } mkind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_INVAL,
        ST_FETCH_SEND,
        ST_FETCH_WAIT,
        ST_REPLY
    } fsm_e;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 32,
    localparam int NID_W  = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output dstate_e           rd_state,
    output logic [NODES-1:0]  rd_sharers,
    output logic [NID_W-1:0]  rd_owner,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dir_we,
    input  dstate_e           dir_state,
    input  logic [NODES-1:0]  dir_sharers,
    input  logic [NID_W-1:0]  dir_owner,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wdata
);

    dstate_e           st_q  [BLOCKS];
    logic [NODES-1:0]  sh_q  [BLOCKS];
    logic [NID_W-1:0]  ow_q  [BLOCKS];
    logic [DATA_W-1:0] mem_q [BLOCKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                st_q[b]  <= DS_UNC;
                sh_q[b]  <= '0;
                ow_q[b]  <= '0;
                mem_q[b] <= '0;
            end
        end else begin
            if (dir_we) begin
                st_q[addr] <= dir_state;
                sh_q[addr] <= dir_sharers;
                ow_q[addr] <= dir_owner;
            end
            if (mem_we) begin
                mem_q[addr] <= mem_wdata;
            end
        end
    end

    assign rd_state   = st_q[addr];
    assign rd_sharers = sh_q[addr];
    assign rd_owner   = ow_q[addr];
    assign rd_data    = mem_q[addr];

    // R3 / R7: an exclusive entry has exactly one sharer bit, the owner's
    a_r3_excl_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == DS_EXC) |-> ($countones(rd_sharers) == 1 && rd_sharers[rd_owner]));

    // R8: an uncached entry has no sharers
    a_r8_uncached_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == DS_UNC) |-> (rd_sharers == '0));

    // R4: a shared entry has at least one sharer
    a_r4_shared_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == DS_SHR) |-> ($countones(rd_sharers) >= 1));

endmodule

// File: rtl/coh_dir_pick.sv
module coh_dir_pick #(
    parameter int NODES = 4,
    localparam int NID_W = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] pending,
    output logic [NODES-1:0] grant,
    output logic [NID_W-1:0] grant_idx
);

    logic found;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (pending[i] && !found) begin
                grant[i]  = 1'b1;
                grant_idx = NID_W'(i);
                found     = 1'b1;
            end
        end
    end

    // R5: exactly one pending destination is served at a time
    a_r5_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> ($countones(grant) == 1 && (grant & pending) != '0));

    // R5: lowest pending node goes first
    a_r5_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> ((pending & (grant - NODES'(1))) == '0));

endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
    import coh_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 32,
    localparam int NID_W  = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NID_W-1:0]  req_node,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [NID_W-1:0]  msg_dest,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);

    localparam logic [NODES-1:0] ONE_BIT = NODES'(1);

    fsm_e              st_q, st_d;
    rkind_e            r_kind;
    logic [NID_W-1:0]  r_node;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [NODES-1:0]  pend_q;

    dstate_e           ent_st;
    logic [NODES-1:0]  ent_sh;
    logic [NID_W-1:0]  ent_ow;
    logic [DATA_W-1:0] ent_data;

    logic              dir_we;
    dstate_e           dir_st;
    logic [NODES-1:0]  dir_sh;
    logic [NID_W-1:0]  dir_ow;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wd;

    logic [NODES-1:0]  req_bit;
    logic [NODES-1:0]  own_bit;
    logic [NODES-1:0]  inv_mask;
    logic [NODES-1:0]  grant;
    logic [NID_W-1:0]  pick_idx;
    logic              wb_hit;

    coh_dir_store #(
        .NODES  (NODES),
        .BLOCKS (BLOCKS),
        .DATA_W (DATA_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (r_addr),
        .rd_state    (ent_st),
        .rd_sharers  (ent_sh),
        .rd_owner    (ent_ow),
        .rd_data     (ent_data),
        .dir_we      (dir_we),
        .dir_state   (dir_st),
        .dir_sharers (dir_sh),
        .dir_owner   (dir_ow),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wd)
    );

    coh_dir_pick #(
        .NODES (NODES)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pend_q),
        .grant     (grant),
        .grant_idx (pick_idx)
    );

    assign req_bit  = ONE_BIT << r_node;
    assign own_bit  = ONE_BIT << ent_ow;
    assign inv_mask = ent_sh & ~req_bit;
    assign wb_hit   = (r_kind == RQ_WB) && (ent_st == DS_EXC) && (ent_ow == r_node);
    assign msg_addr = r_addr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // captured request and pending invalidate vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_kind  <= RQ_RD;
            r_node  <= '0;
            r_addr  <= '0;
            r_wdata <= '0;
            pend_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && req_valid) begin
                r_kind  <= rkind_e'(req_kind);
                r_node  <= req_node;
                r_addr  <= req_addr;
                r_wdata <= req_wdata;
            end
            if (st_q == ST_DISPATCH) begin
                pend_q <= (r_kind == RQ_WR && ent_st == DS_SHR) ? inv_mask : '0;
            end else if (st_q == ST_INVAL) begin
                pend_q <= pend_q & ~grant;
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) st_d = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                unique case (r_kind)
                    RQ_RD: st_d = (ent_st == DS_EXC) ? ST_FETCH_SEND : ST_REPLY;
                    RQ_WR: begin
                        if (ent_st == DS_EXC)                         st_d = ST_FETCH_SEND;
                        else if (ent_st == DS_SHR && inv_mask != '0)  st_d = ST_INVAL;
                        else                                          st_d = ST_REPLY;
                    end
                    default: st_d = ST_IDLE;
                endcase
            end
            ST_INVAL: begin
                if ((pend_q & ~grant) == '0) st_d = ST_REPLY;
            end
            ST_FETCH_SEND: st_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: begin
                if (rsp_valid) st_d = ST_REPLY;
            end
            ST_REPLY: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs and directory/memory writes
    always_comb begin
        req_ready = 1'b0;
        msg_valid = 1'b0;
        msg_kind  = MG_DATA;
        msg_dest  = r_node;
        msg_data  = '0;
        dir_we    = 1'b0;
        dir_st    = ent_st;
        dir_sh    = ent_sh;
        dir_ow    = ent_ow;
        mem_we    = 1'b0;
        mem_wd    = rsp_data;
        unique case (st_q)
            ST_IDLE: req_ready = 1'b1;
            ST_DISPATCH: begin
                if (wb_hit) begin
                    mem_we = 1'b1;
                    mem_wd = r_wdata;
                    dir_we = 1'b1;
                    dir_st = DS_UNC;
                    dir_sh = '0;
                    dir_ow = '0;
                end
            end
            ST_INVAL: begin
                msg_valid = 1'b1;
                msg_kind  = MG_INV;
                msg_dest  = pick_idx;
            end
            ST_FETCH_SEND: begin
                msg_valid = 1'b1;
                msg_kind  = (r_kind == RQ_RD) ? MG_FETCH : MG_FETCH_INV;
                msg_dest  = ent_ow;
            end
            ST_FETCH_WAIT: begin
                mem_we = rsp_valid;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = MG_DATA;
                msg_data  = ent_data;
                dir_we    = 1'b1;
                if (r_kind == RQ_RD) begin
                    dir_st = DS_SHR;
                    unique case (ent_st)
                        DS_EXC:  dir_sh = own_bit | req_bit;
                        DS_SHR:  dir_sh = ent_sh | req_bit;
                        default: dir_sh = req_bit;
                    endcase
                end else begin
                    dir_st = DS_EXC;
                    dir_sh = req_bit;
                    dir_ow = r_node;
                end
            end
            default: ;
        endcase
    end

    // R5: the requester never receives an invalidate for its own miss
    a_r5_inv_not_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MG_INV) |-> (msg_dest != r_node));

    // R10: no second request is taken while one is in progress
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: the data reply finishes the request
    a_r10_reply_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MG_DATA) |=> req_ready);

    // R6: the controller keeps waiting until the owner answers
    a_r6_hold_for_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH_WAIT && !rsp_valid) |=> (st_q == ST_FETCH_WAIT && !msg_valid));

    // R8: a write-back never produces a message in the following cycle
    a_r8_wb_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DISPATCH && r_kind == RQ_WB) |=> (!msg_valid && req_ready));

endmodule

// File: tb/coh_dir_home_tb.sv
module coh_dir_home_tb;

    localparam int NODES  = 4;
    localparam int BLOCKS = 4;
    localparam int DATA_W = 32;
    localparam int NID_W  = 2;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [NID_W-1:0]  req_node = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid = 1'b0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              msg_valid;
    logic [1:0]        msg_kind;
    logic [NID_W-1:0]  msg_dest;
    logic [ADDR_W-1:0] msg_addr;
    logic [DATA_W-1:0] msg_data;

    always #2 clk = ~clk;

    coh_dir_home #(
        .NODES  (NODES),
        .BLOCKS (BLOCKS),
        .DATA_W (DATA_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_node  (req_node),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .msg_valid (msg_valid),
        .msg_kind  (msg_kind),
        .msg_dest  (msg_dest),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int seq      = 0;

    // reference model: 0 uncached, 1 shared, 2 exclusive
    int          m_st  [BLOCKS];
    logic [3:0]  m_sh  [BLOCKS];
    int          m_ow  [BLOCKS];
    logic [31:0] m_mem [BLOCKS];

    int          e_n;
    int          e_kind [8];
    int          e_dest [8];
    logic [31:0] e_data [8];
    int          e_cyc  [8];

    int          g_n;
    int          g_kind [16];
    int          g_dest [16];
    logic [31:0] g_data [16];
    int          g_cyc  [16];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input int k, input int d, input logic [31:0] v, inout int c);
        e_kind[e_n] = k;
        e_dest[e_n] = d;
        e_data[e_n] = v;
        e_cyc[e_n]  = c;
        e_n++;
        c++;
    endtask

    // kind: 0 read miss, 1 write miss, 2 write-back, 3 ignored
    task automatic run_req(input int kind, input int node, input int addr,
                           input logic [31:0] wd, input string tag);
        int c = 1;
        logic [31:0] rv;
        bit pend = 0;
        seq++;
        e_n = 0;
        rv  = 32'hA500_0000 + 32'(seq * 256) + 32'(m_ow[addr] * 16) + 32'(addr);
        if (kind == 0) begin
            if (m_st[addr] == 2) begin
                push_exp(2, m_ow[addr], 32'h0, c);
                c++;
                m_mem[addr] = rv;
                m_sh[addr]  = (4'b1 << m_ow[addr]) | (4'b1 << node);
            end else if (m_st[addr] == 1) begin
                m_sh[addr] = m_sh[addr] | (4'b1 << node);
            end else begin
                m_sh[addr] = 4'b1 << node;
            end
            push_exp(0, node, m_mem[addr], c);
            m_st[addr] = 1;
        end else if (kind == 1) begin
            if (m_st[addr] == 2) begin
                push_exp(3, m_ow[addr], 32'h0, c);
                c++;
                m_mem[addr] = rv;
            end else if (m_st[addr] == 1) begin
                for (int i = 0; i < NODES; i++)
                    if (m_sh[addr][i] && i != node) push_exp(1, i, 32'h0, c);
            end
            push_exp(0, node, m_mem[addr], c);
            m_st[addr] = 2;
            m_sh[addr] = 4'b1 << node;
            m_ow[addr] = node;
        end else if (kind == 2 && m_st[addr] == 2 && m_ow[addr] == node) begin
            m_mem[addr] = wd;
            m_st[addr]  = 0;
            m_sh[addr]  = '0;
        end

        @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready before request", 32'(req_ready), 32'h1);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_node  = NID_W'(node);
        req_addr  = ADDR_W'(addr);
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "ready while busy", 32'(req_ready), 32'h0);
        g_n = 0;
        for (int t = 1; t < 40; t++) begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (pend) begin
                rsp_valid = 1'b1;
                rsp_data  = rv;
                pend      = 0;
            end
            if (msg_valid && g_n < 16) begin
                g_kind[g_n] = int'(msg_kind);
                g_dest[g_n] = int'(msg_dest);
                g_data[g_n] = msg_data;
                g_cyc[g_n]  = t;
                check(msg_addr == ADDR_W'(addr), tag, "message block", 32'(msg_addr), 32'(addr));
                if (msg_kind >= 2) pend = 1;
                g_n++;
            end
            if (req_ready) break;
        end
        rsp_valid = 1'b0;

        check(g_n == e_n, tag, "message count", 32'(g_n), 32'(e_n));
        for (int j = 0; j < e_n && j < g_n; j++) begin
            check(g_kind[j] == e_kind[j], tag, "message kind", 32'(g_kind[j]), 32'(e_kind[j]));
            check(g_dest[j] == e_dest[j], tag, "message dest", 32'(g_dest[j]), 32'(e_dest[j]));
            check(g_cyc[j] == e_cyc[j], "R10", "message cycle", 32'(g_cyc[j]), 32'(e_cyc[j]));
            if (e_kind[j] == 0)
                check(g_data[j] == e_data[j], tag, "reply data", g_data[j], e_data[j]);
        end
    endtask

    task automatic t_reset_state();
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
        check(msg_valid == 1'b0, "R1", "no message after reset", 32'(msg_valid), 32'h0);
    endtask

    task automatic t_read_fill();
        run_req(0, 0, 0, 32'h0, "R2");   // first read of uncached block, zero data (R1)
        run_req(0, 2, 0, 32'h0, "R4");
        run_req(0, 3, 0, 32'h0, "R4");
    endtask

    task automatic t_write_shared();
        run_req(1, 2, 0, 32'h0, "R5");   // invalidates 0 and 3, requester 2 skipped
    endtask

    task automatic t_read_exclusive();
        run_req(0, 1, 0, 32'h0, "R6");   // fetch from owner 2
        run_req(1, 3, 0, 32'h0, "R5");   // invalidates 1 and 2: both shared after R6
    endtask

    task automatic t_write_exclusive();
        run_req(1, 0, 0, 32'h0, "R7");   // fetch-and-invalidate to owner 3
        run_req(0, 1, 0, 32'h0, "R7");   // fetch goes to new owner 0
    endtask

    task automatic t_writeback();
        run_req(1, 2, 0, 32'h0, "R5");          // 0 and 1 invalidated, 2 owns
        run_req(2, 1, 0, 32'hDEAD_0001, "R9");  // non-owner write-back dropped
        run_req(3, 2, 0, 32'hDEAD_0002, "R9");  // reserved kind dropped
        run_req(2, 2, 0, 32'h1234_5678, "R8");  // owner write-back
        run_req(0, 3, 0, 32'h0, "R8");          // uncached: no fetch, written data
        run_req(1, 1, 0, 32'h0, "R8");          // only node 3 invalidated
    endtask

    task automatic t_write_uncached();
        run_req(1, 1, 2, 32'h0, "R3");
        run_req(0, 2, 2, 32'h0, "R3");          // fetch to owner 1 shows exclusive
    endtask

    task automatic t_wb_not_exclusive();
        run_req(2, 0, 1, 32'hBEEF_0003, "R9");  // uncached block
        run_req(0, 0, 1, 32'h0, "R9");          // memory still zero
        run_req(2, 0, 1, 32'hBEEF_0004, "R9");  // shared block
        run_req(0, 3, 1, 32'h0, "R9");          // still zero, still shared
    endtask

    task automatic t_owner_roundtrip();
        run_req(1, 1, 3, 32'h0, "R3");
        run_req(2, 1, 3, 32'h0BAD_CAFE, "R8");
        run_req(1, 1, 3, 32'h0, "R3");          // no invalidate to self, data written back
    endtask

    initial begin
        for (int b = 0; b < BLOCKS; b++) begin
            m_st[b]  = 0;
            m_sh[b]  = '0;
            m_ow[b]  = 0;
            m_mem[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_read_fill();
        t_write_shared();
        t_read_exclusive();
        t_write_exclusive();
        t_writeback();
        t_write_uncached();
        t_wb_not_exclusive();
        t_owner_roundtrip();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule